// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Unit

This block watches one already-filtered pin level and turns qualifying activity on it into two sticky status bits: an interrupt status and a wake status. Software picks the detection style per pin. A trigger-type bit chooses between edge and level sensing, and a two-bit polarity field chooses low/falling, high/rising or both edges. Separate controls decide whether an event is latched, whether a latched event is delivered, and in which sleep states it also raises wake.

Both status bits are write-one-to-clear. The `pending` output feeds a chip-level status aggregator. It is high when either status bit is set and the pin is both enabled and unmasked. Debounce filtering, pad drive and pull resistors are outside this block.

Top module: `pin_irq_trigger`

## Requirements
- R1: After reset `intSts`, `wakeSts` and `pending` are all 0.
- R2: With `trigLevel`=0, `activeSel`=01 sets `intSts` on the clock edge where a rising pin level is first sampled. `activeSel`=00 does the same for a falling level. `activeSel`=10 does it for either change. A steady level sets nothing.
- R3: With `trigLevel`=1, `activeSel`=01 sets `intSts` on every clock edge where the pin is 1. `activeSel`=00 does so on every edge where the pin is 0. `activeSel`=10 sets nothing in this mode.
- R4: `activeSel`=11 never sets either status bit, in either trigger mode.
- R5: `intSts` is only set while `intEn`=1. With `intEn`=0 no event latches it.
- R6: An event latches `intSts` even while `intUnmask`=0. `pending` stays 0 while `intUnmask`=0 and follows the status once `intUnmask` returns to 1.
- R7: `pending` is 1 exactly when `intEn`=1, `intUnmask`=1 and at least one of `intSts` or `wakeSts` is 1.
- R8: `sleepState` codes are: 0 = awake, k (1..3) = sleep state k. An event sets `wakeSts` only when `sleepState`=k and `wakeEn[k-1]`=1. With `sleepState`=0 no wake status is set. Wake latching does not depend on `intEn`.
- R9: A 1 on `clrIntSts` or `clrWakeSts` clears only the matching status bit at the next clock edge.
- R10: In level mode a clear does not stick while the active level persists. It sticks once the level has gone inactive.
- R11: When an event and a clear of the same bit meet in one cycle, the bit is left set.
- R12: The first pin sample after reset is never treated as an edge, whatever the pin level is during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pinLevel | input | 1 | Filtered pin level |
| trigLevel | input | 1 | 0 = edge detection, 1 = level detection |
| activeSel | input | 2 | 00 low/falling, 01 high/rising, 10 both edges, 11 none |
| intEn | input | 1 | Allows events to latch interrupt status |
| intUnmask | input | 1 | 1 lets status reach `pending` |
| wakeEn | input | 3 | Wake enable per sleep state, bit k-1 for state k |
| sleepState | input | 2 | Current power state: 0 awake, 1..3 sleep |
| clrIntSts | input | 1 | Write-one-to-clear of interrupt status |
| clrWakeSts | input | 1 | Write-one-to-clear of wake status |
| intSts | output | 1 | Latched interrupt status |
| wakeSts | output | 1 | Latched wake status |
| pending | output | 1 | Request to the status aggregator |

## Verification
The hardest case to reach is the level-mode clear attempt, where the clear races a set that comes back every cycle. The bench holds the active level, pulses the clear and checks that the bit stays set. It then drops the level and clears in the same cycle, and checks that the bit falls. The edge/level/polarity cross-product runs as a sweep over every previous and current pin value. Before each case the bench prepares the pin with the enable off and clears any stale status. As a result, each sampled edge isolates exactly one transition. Reset with the pin held high covers the spurious-first-edge hazard.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  typedef enum logic [1:0] {
    ACT_LOW  = 2'b00,
    ACT_HIGH = 2'b01,
    ACT_BOTH = 2'b10,
    ACT_NONE = 2'b11
  } act_sel_e;

  typedef struct packed {
    logic setInt;
    logic setWake;
    logic clrInt;
    logic clrWake;
  } trig_strobe_t;
endpackage

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int SLEEP_STATES = 3,
  parameter int SS_W = $clog2(SLEEP_STATES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pinLevel,
  input  logic                    trigLevel,
  input  logic [1:0]              activeSel,
  input  logic                    intEn,
  input  logic [SLEEP_STATES-1:0] wakeEn,
  input  logic [SS_W-1:0]         sleepState,
  input  logic                    clrIntSts,
  input  logic                    clrWakeSts,
  output trig_strobe_t            strobes
);
  logic prevLevel;
  logic primed;
  logic rise, fall;
  logic edgeHit, levelHit, hit;
  logic wakeArmed;

  // Previous-sample register; primed blocks a false edge on the first sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevLevel <= 1'b0;
      primed    <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      primed    <= 1'b1;
    end
  end

  always_comb begin
    rise = primed & pinLevel & ~prevLevel;
    fall = primed & ~pinLevel & prevLevel;
    unique case (act_sel_e'(activeSel))
      ACT_LOW:  begin edgeHit = fall;        levelHit = ~pinLevel; end
      ACT_HIGH: begin edgeHit = rise;        levelHit = pinLevel;  end
      ACT_BOTH: begin edgeHit = rise | fall; levelHit = 1'b0;      end
      default:  begin edgeHit = 1'b0;        levelHit = 1'b0;      end
    endcase
    hit = trigLevel ? levelHit : edgeHit;
  end

  // One wake enable per sleep state, selected by the current state code.
  logic [SLEEP_STATES-1:0] wakeSel;
  for (genvar gi = 0; gi < SLEEP_STATES; gi++) begin : g_wake
    assign wakeSel[gi] = wakeEn[gi] & (sleepState == SS_W'(gi + 1));
  end
  assign wakeArmed = |wakeSel;

  always_comb begin
    strobes.setInt  = hit & intEn;
    strobes.setWake = hit & wakeArmed;
    strobes.clrInt  = clrIntSts;
    strobes.clrWake = clrWakeSts;
  end
endmodule

// File: rtl/pin_irq_dp.sv
module pin_irq_dp
  import pin_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  trig_strobe_t strobes,
  input  logic         intEn,
  input  logic         intUnmask,
  output logic         intSts,
  output logic         wakeSts,
  output logic         pending
);
  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intSts  <= 1'b0;
      wakeSts <= 1'b0;
    end else begin
      intSts  <= strobes.setInt  | (intSts  & ~strobes.clrInt);
      wakeSts <= strobes.setWake | (wakeSts & ~strobes.clrWake);
    end
  end

  assign pending = intEn & intUnmask & (intSts | wakeSts);
endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger
  import pin_irq_pkg::*;
#(
  parameter int SLEEP_STATES = 3,
  localparam int SS_W = $clog2(SLEEP_STATES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pinLevel,
  input  logic                    trigLevel,
  input  logic [1:0]              activeSel,
  input  logic                    intEn,
  input  logic                    intUnmask,
  input  logic [SLEEP_STATES-1:0] wakeEn,
  input  logic [SS_W-1:0]         sleepState,
  input  logic                    clrIntSts,
  input  logic                    clrWakeSts,
  output logic                    intSts,
  output logic                    wakeSts,
  output logic                    pending
);
  trig_strobe_t strobes;

  pin_irq_ctrl #(.SLEEP_STATES(SLEEP_STATES), .SS_W(SS_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pinLevel   (pinLevel),
    .trigLevel  (trigLevel),
    .activeSel  (activeSel),
    .intEn      (intEn),
    .wakeEn     (wakeEn),
    .sleepState (sleepState),
    .clrIntSts  (clrIntSts),
    .clrWakeSts (clrWakeSts),
    .strobes    (strobes)
  );

  pin_irq_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .intEn     (intEn),
    .intUnmask (intUnmask),
    .intSts    (intSts),
    .wakeSts   (wakeSts),
    .pending   (pending)
  );
endmodule

// File: rtl/pin_irq_trigger_chk.sv
module pin_irq_trigger_chk
  import pin_irq_pkg::*;
#(
  parameter int SS_W = 2
) (
  input logic         clk,
  input logic         rst_n,
  input trig_strobe_t strobes,
  input logic [1:0]   activeSel,
  input logic         intEn,
  input logic         intUnmask,
  input logic [SS_W-1:0] sleepState,
  input logic         intSts,
  input logic         wakeSts,
  input logic         pending
);
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setInt |=> intSts);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrInt && !strobes.setInt) |=> !intSts);
  a_r9_wake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrWake && !strobes.setWake) |=> !wakeSts);
  a_r4_undefined: assert property (@(posedge clk) disable iff (!rst_n)
    (activeSel == 2'b11) |-> (!strobes.setInt && !strobes.setWake));
  a_r5_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !intEn |-> !strobes.setInt);
  a_r7_pending_gate: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (intEn && intUnmask));
  a_r8_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepState == '0) |-> !strobes.setWake);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.setInt && !strobes.clrInt) |=> $stable(intSts));
endmodule

bind pin_irq_trigger pin_irq_trigger_chk #(.SS_W(SS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobes    (strobes),
  .activeSel  (activeSel),
  .intEn      (intEn),
  .intUnmask  (intUnmask),
  .sleepState (sleepState),
  .intSts     (intSts),
  .wakeSts    (wakeSts),
  .pending    (pending)
);

// File: tb/pin_irq_trigger_tb.sv
`timescale 1ns/1ps
module pin_irq_trigger_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pinLevel = 1'b0;
  logic trigLevel = 1'b0;
  logic [1:0] activeSel = 2'b01;
  logic intEn = 1'b0;
  logic intUnmask = 1'b0;
  logic [2:0] wakeEn = 3'b000;
  logic [1:0] sleepState = 2'b00;
  logic clrIntSts = 1'b0;
  logic clrWakeSts = 1'b0;
  logic intSts, wakeSts, pending;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pin_irq_trigger u_dut (
    .clk(clk), .rst_n(rst_n), .pinLevel(pinLevel), .trigLevel(trigLevel),
    .activeSel(activeSel), .intEn(intEn), .intUnmask(intUnmask),
    .wakeEn(wakeEn), .sleepState(sleepState), .clrIntSts(clrIntSts),
    .clrWakeSts(clrWakeSts), .intSts(intSts), .wakeSts(wakeSts),
    .pending(pending)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic model_hit(logic lvl, logic [1:0] sel, logic prv, logic cur);
    if (sel == 2'b11) return 1'b0;
    if (lvl) begin
      if (sel == 2'b01) return cur;
      if (sel == 2'b00) return ~cur;
      return 1'b0;
    end
    if (sel == 2'b01) return cur & ~prv;
    if (sel == 2'b00) return ~cur & prv;
    return cur ^ prv;
  endfunction

  task automatic clear_all();
    clrIntSts = 1'b1; clrWakeSts = 1'b1;
    step();
    clrIntSts = 1'b0; clrWakeSts = 1'b0;
  endtask

  initial begin
    // R12: reset with the pin high, rising edge armed
    pinLevel = 1'b1; activeSel = 2'b01; intEn = 1'b1; intUnmask = 1'b1;
    step(); step();
    chk("R1 intSts in reset", intSts, 1'b0);
    chk("R1 wakeSts in reset", wakeSts, 1'b0);
    chk("R1 pending in reset", pending, 1'b0);
    rst_n = 1'b1;
    step(); step(); step();
    chk("R12 no edge on first sample", intSts, 1'b0);

    // R2 R3 R4 R5 sweep: mode x polarity x enable x transition
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int e = 0; e < 2; e++)
          for (int t = 0; t < 4; t++) begin
            logic prv, cur, exp;
            prv = t[1]; cur = t[0];
            intEn = 1'b0; wakeEn = 3'b000; sleepState = 2'b00;
            trigLevel = m[0]; activeSel = s[1:0];
            pinLevel = prv;
            step(); step();
            clear_all();
            intEn = e[0]; pinLevel = cur;
            step();
            exp = e[0] & model_hit(m[0], s[1:0], prv, cur);
            chk($sformatf("R2/R3/R4/R5 sweep mode=%0d sel=%0d en=%0d %0d->%0d",
                          m, s, e, prv, cur), intSts, exp);
          end

    // R8 wake sweep, rising edge, intEn off
    trigLevel = 1'b0; activeSel = 2'b01; intUnmask = 1'b1;
    for (int ss = 0; ss < 4; ss++)
      for (int we = 0; we < 8; we++) begin
        logic exp;
        intEn = 1'b0; pinLevel = 1'b0;
        sleepState = ss[1:0]; wakeEn = we[2:0];
        step(); step();
        clear_all();
        pinLevel = 1'b1;
        step();
        exp = (ss != 0) && we[ss-1];
        chk($sformatf("R8 wake ss=%0d en=%0d", ss, we), wakeSts, exp);
        chk("R5 no intSts with enable off", intSts, 1'b0);
      end

    // R9 clears are independent
    sleepState = 2'b01; wakeEn = 3'b001; intEn = 1'b1;
    pinLevel = 1'b0; step(); step(); clear_all();
    pinLevel = 1'b1; step();
    chk("R9 setup int", intSts, 1'b1);
    chk("R9 setup wake", wakeSts, 1'b1);
    clrIntSts = 1'b1; step(); clrIntSts = 1'b0;
    chk("R9 int cleared", intSts, 1'b0);
    chk("R9 wake kept", wakeSts, 1'b1);
    // R7 wake alone drives pending
    chk("R7 pending from wake only", pending, 1'b1);
    clrWakeSts = 1'b1; step(); clrWakeSts = 1'b0;
    chk("R9 wake cleared", wakeSts, 1'b0);
    chk("R7 pending low when idle", pending, 1'b0);

    // R11 event and clear in one cycle
    sleepState = 2'b00; wakeEn = 3'b000;
    pinLevel = 1'b0; step(); step();
    pinLevel = 1'b1; step();
    pinLevel = 1'b0; step();
    pinLevel = 1'b1; clrIntSts = 1'b1; step(); clrIntSts = 1'b0;
    chk("R11 set wins over clear", intSts, 1'b1);

    // R6 latch while masked, R7 enable gating
    clear_all();
    intUnmask = 1'b0; pinLevel = 1'b0; step();
    pinLevel = 1'b1; step();
    chk("R6 latched while masked", intSts, 1'b1);
    chk("R6 pending masked", pending, 1'b0);
    intUnmask = 1'b1; #1;
    chk("R6 pending after unmask", pending, 1'b1);
    intEn = 1'b0; #1;
    chk("R7 pending needs enable", pending, 1'b0);
    chk("R7 status held with enable off", intSts, 1'b1);
    intEn = 1'b1;

    // R10 level-mode clear
    clear_all();
    trigLevel = 1'b1; activeSel = 2'b01; pinLevel = 1'b1; step();
    chk("R3 level sets", intSts, 1'b1);
    clrIntSts = 1'b1; step(); clrIntSts = 1'b0;
    chk("R10 clear does not stick while active", intSts, 1'b1);
    pinLevel = 1'b0; clrIntSts = 1'b1; step(); clrIntSts = 1'b0;
    chk("R10 clear sticks when inactive", intSts, 1'b0);
    step();
    chk("R10 stays clear", intSts, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule